// File: doc/BRIEF.md
# Serial Line Automatic Power-Down Controller

This controller decides, one clock at a time, whether a serial line interface is powered up or down. It takes one "valid level seen" flag per receiver from external comparators, plus three control pins: an active-low force-off, an active-high force-on and an active-low receiver enable. From these it drives the charge-pump enable, the transmitter enable and the receiver output enable. It also drives an active-low signal-presence status, `invalid_n`, which is high while at least one receiver carries a valid level.

The presence detector is deliberately asymmetric. A valid level has to persist only briefly before it is accepted, but a loss of all valid levels has to persist much longer before it is reported. Every interval is a parameter expressed in clock cycles. Each qualification timer restarts as soon as its condition is broken.

Power-up runs in a fixed order. The charge pump is enabled first, and the transmitters follow only after a wake interval. In automatic mode a grace window then follows. If signal presence does not return within that window, the interface drops back to power-down. Force-off overrides everything. Force-on holds the interface up whatever the line activity.

Top module: `serial_pwr_ctrl`

## Requirements
- R1: While `force_off_n` is 0, `tx_en` and `pump_en` are both 0 from the cycle after the clock edge that samples it, whatever `force_on` and the receiver levels are.
- R2: With `force_off_n`=1 and `force_on`=1, a powered-down interface starts waking on the next edge. Once `tx_en` is 1, it stays 1 regardless of receiver levels.
- R3: On every power-up, `pump_en` goes to 1 first. `tx_en` goes to 1 exactly WAKE_CYC cycles later, and `tx_en` never rises while `pump_en` is 0.
- R4: Each `lvl_ok` bit passes through a two-flop synchroniser. `invalid_n` rises 2+INVH_CYC edges after any `lvl_ok` bit rises and stays high.
- R5: `invalid_n` falls 2+INVL_CYC edges after all `lvl_ok` bits go to 0. A valid level appearing during that count restarts it.
- R6: A valid level that lasts fewer than INVH_CYC synchronised cycles leaves `invalid_n` at 0.
- R7: In automatic mode (`force_off_n`=1, `force_on`=0), the interface starts waking on the edge after `invalid_n` becomes 1.
- R8: In automatic mode, an interface that is up with its grace window over powers down (`tx_en`=0, `pump_en`=0) on the edge after `invalid_n` becomes 0.
- R9: In automatic mode, if `invalid_n` is 0 when the wake interval ends, `tx_en` is held at 1 for GRACE_CYC cycles and then dropped. If `invalid_n` returns to 1 within that window, the interface stays up.
- R10: `rx_oe` equals the inverse of `rx_en_n` in every mode, including power-down, within the same cycle.
- R11: During and after reset, `tx_en`, `pump_en` and `invalid_n` are 0 until qualified activity changes them.
- R12: `invalid_n` follows receiver activity in the forced-off and forced-on modes as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_ok | input | N_RX | Per-receiver valid-level flags, asynchronous |
| force_off_n | input | 1 | Active-low power-down override |
| force_on | input | 1 | Active-high automatic power-down disable |
| rx_en_n | input | 1 | Active-low receiver output enable |
| tx_en | output | 1 | Transmitter enable |
| pump_en | output | 1 | Charge-pump enable |
| rx_oe | output | 1 | Receiver output enable |
| invalid_n | output | 1 | Low while no valid level has been qualified |

## Verification
Each result is due at a different latency:

- `rx_oe` follows `rx_en_n` within the same cycle.
- `pump_en` and `tx_en` react one edge after a control or presence change.
- `invalid_n` lags `lvl_ok` by the two synchroniser stages plus INVH_CYC or INVL_CYC.
- `tx_en` trails `pump_en` by WAKE_CYC.

A behavioural model in the bench advances by those rules at every rising edge. Stimulus changes 2 ns after the edge, and all four outputs are compared with the model at the falling edge. Directed checks add exact counts of the wake interval and the outcome of each grace window.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        PW_OFF   = 2'd0,
        PW_WAKE  = 2'd1,
        PW_GRACE = 2'd2,
        PW_ON    = 2'd3
    } pwr_state_t;

    typedef struct packed {
        logic pump;
        logic tx;
    } drive_t;

    function automatic drive_t decode_drive(pwr_state_t st);
        drive_t d;
        d.pump = (st != PW_OFF);
        d.tx   = (st == PW_GRACE) || (st == PW_ON);
        return d;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
    parameter int N_RX = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_RX-1:0] raw,
    output logic            any_sync
);
    logic [N_RX-1:0] stage1;
    logic [N_RX-1:0] stage2;

    genvar i;
    generate
        for (i = 0; i < N_RX; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1[i] <= 1'b0;
                    stage2[i] <= 1'b0;
                end else begin
                    stage1[i] <= raw[i];
                    stage2[i] <= stage1[i];
                end
            end
        end
    endgenerate

    assign any_sync = |stage2;

    // R4
    sync_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (any_sync && !$past(rst)) |-> $past(|stage1));
endmodule

// File: rtl/spc_presence.sv
module spc_presence #(
    parameter int INVL_CYC = 6,
    parameter int INVH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic any_valid,
    output logic present
);
    import spc_pkg::*;

    localparam int CW = $clog2(max2(INVL_CYC, INVH_CYC) + 1);

    logic [CW-1:0] run_q;
    logic [CW-1:0] lim;
    logic          valid_q;

    always_comb begin
        lim = valid_q ? CW'(INVL_CYC - 1) : CW'(INVH_CYC - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            run_q   <= '0;
        end else if (any_valid == valid_q) begin
            run_q <= '0;
        end else if (run_q == lim) begin
            valid_q <= ~valid_q;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign present = valid_q;

    // R4
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_q) |-> $past(any_valid));

    // R5
    fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(valid_q) |-> !$past(any_valid));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_q && !any_valid) |=> !valid_q);
endmodule

// File: rtl/spc_power_fsm.sv
module spc_power_fsm #(
    parameter int WAKE_CYC  = 12,
    parameter int GRACE_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic force_off_n,
    input  logic force_on,
    input  logic present,
    output logic pump_en,
    output logic tx_en
);
    import spc_pkg::*;

    localparam int TW = $clog2(max2(WAKE_CYC, GRACE_CYC) + 1);

    pwr_state_t    state_q, state_d;
    logic [TW-1:0] tmr_q, tmr_d;
    drive_t        drv;

    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        case (state_q)
            PW_OFF: begin
                tmr_d = '0;
                if (force_on || present) state_d = PW_WAKE;
            end
            PW_WAKE: begin
                if (tmr_q == TW'(WAKE_CYC - 1)) begin
                    state_d = force_on ? PW_ON : PW_GRACE;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            PW_GRACE: begin
                if (force_on || present) begin
                    state_d = PW_ON;
                    tmr_d   = '0;
                end else if (tmr_q == TW'(GRACE_CYC - 1)) begin
                    state_d = PW_OFF;
                    tmr_d   = '0;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
            default: begin
                tmr_d = '0;
                if (!force_on && !present) state_d = PW_OFF;
            end
        endcase
        if (!force_off_n) begin
            state_d = PW_OFF;
            tmr_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_OFF;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
        end
    end

    assign drv     = decode_drive(state_q);
    assign pump_en = drv.pump;
    assign tx_en   = drv.tx;

    // R1
    force_off_chk: assert property (@(posedge clk) disable iff (rst)
        !force_off_n |=> (!tx_en && !pump_en));

    // R3
    pump_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> $past(pump_en));

    // R2
    forced_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (force_off_n && force_on && tx_en) |=> tx_en);

    // R8
    auto_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (force_off_n && !force_on && !present && state_q == PW_ON) |=> !pump_en);
endmodule

// File: rtl/serial_pwr_ctrl.sv
module serial_pwr_ctrl #(
    parameter int N_RX      = 2,
    parameter int INVL_CYC  = 6,
    parameter int INVH_CYC  = 2,
    parameter int WAKE_CYC  = 12,
    parameter int GRACE_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_RX-1:0] lvl_ok,
    input  logic            force_off_n,
    input  logic            force_on,
    input  logic            rx_en_n,
    output logic            tx_en,
    output logic            pump_en,
    output logic            rx_oe,
    output logic            invalid_n
);
    logic any_valid;
    logic present;

    spc_sync #(.N_RX(N_RX)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (lvl_ok),
        .any_sync (any_valid)
    );

    spc_presence #(.INVL_CYC(INVL_CYC), .INVH_CYC(INVH_CYC)) u_pres (
        .clk       (clk),
        .rst       (rst),
        .any_valid (any_valid),
        .present   (present)
    );

    spc_power_fsm #(.WAKE_CYC(WAKE_CYC), .GRACE_CYC(GRACE_CYC)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .force_off_n (force_off_n),
        .force_on    (force_on),
        .present     (present),
        .pump_en     (pump_en),
        .tx_en       (tx_en)
    );

    assign rx_oe     = ~rx_en_n;
    assign invalid_n = present;

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!tx_en && !pump_en && !invalid_n));
endmodule

// File: tb/serial_pwr_ctrl_test.sv
module serial_pwr_ctrl_test;
    localparam int N_RX = 2, INVL = 6, INVH = 2, WAKE = 12, GRACE = 8;

    logic clk = 0, rst = 1;
    logic [N_RX-1:0] lvl_ok = '0;
    logic force_off_n = 0, force_on = 0, rx_en_n = 0;
    logic tx_en, pump_en, rx_oe, invalid_n;

    serial_pwr_ctrl #(.N_RX(N_RX), .INVL_CYC(INVL), .INVH_CYC(INVH),
                      .WAKE_CYC(WAKE), .GRACE_CYC(GRACE)) uut (
        .clk(clk), .rst(rst), .lvl_ok(lvl_ok), .force_off_n(force_off_n),
        .force_on(force_on), .rx_en_n(rx_en_n), .tx_en(tx_en),
        .pump_en(pump_en), .rx_oe(rx_oe), .invalid_n(invalid_n));

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    string phase = "R11";
    bit done = 0;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: power phase 0 down, 1 waking, 2 grace, 3 up
    int s1 = 0, s2 = 0, m_valid = 0, m_run = 0, m_ph = 0, m_t = 0;
    always @(posedge clk) begin
        int lim, old_valid;
        if (rst) begin
            s1 = 0; s2 = 0; m_valid = 0; m_run = 0; m_ph = 0; m_t = 0;
        end else begin
            old_valid = m_valid;
            lim = m_valid ? INVL : INVH;
            if (s2 != m_valid) begin
                m_run++;
                if (m_run == lim) begin m_valid = 1 - m_valid; m_run = 0; end
            end else m_run = 0;
            if (!force_off_n) begin m_ph = 0; m_t = 0; end
            else if (m_ph == 0) begin
                if (force_on || old_valid) begin m_ph = 1; m_t = 0; end
            end else if (m_ph == 1) begin
                m_t++;
                if (m_t == WAKE) begin m_ph = force_on ? 3 : 2; m_t = 0; end
            end else if (m_ph == 2) begin
                if (force_on || old_valid) m_ph = 3;
                else begin m_t++; if (m_t == GRACE) begin m_ph = 0; m_t = 0; end end
            end else if (!force_on && !old_valid) m_ph = 0;
            s2 = s1;
            s1 = (lvl_ok != 0) ? 1 : 0;
        end
    end

    int pump_only = 0;
    always @(negedge clk) begin
        if (!done) begin
            check(phase, "pump_en", pump_en, m_ph != 0);
            check(phase, "tx_en", tx_en, m_ph >= 2);
            check(phase, "invalid_n", invalid_n, m_valid);
            check("R10", "rx_oe", rx_oe, !rx_en_n);
            if (pump_en && !tx_en) pump_only++;
        end
    end

    task automatic run(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_up();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        run(4);
        rst = 0;
        #8;
        check("R11", "reset tx_en", tx_en, 0);
        check("R11", "reset pump_en", pump_en, 0);
        check("R11", "reset invalid_n", invalid_n, 0);
        run(3);

        phase = "R1"; force_off_n = 0; force_on = 1; lvl_ok = 2'b11;
        run(20);
        check("R1", "forced off tx_en", tx_en, 0);
        check("R12", "invalid_n while forced off", invalid_n, 1);
        rx_en_n = 1; #1;
        check("R10", "rx_oe in power-down", rx_oe, 0);

        phase = "R2"; pump_only = 0; force_off_n = 1; lvl_ok = '0;
        run(40);
        check("R3", "pump-only cycles", pump_only, WAKE);
        check("R2", "forced on tx_en", tx_en, 1);
        check("R12", "invalid_n while forced on", invalid_n, 0);
        rx_en_n = 0; #1;
        check("R10", "rx_oe enabled", rx_oe, 1);

        phase = "R8"; force_on = 0;
        run(4);
        check("R8", "auto drop tx_en", tx_en, 0);

        phase = "R6"; lvl_ok = 2'b01; run(1); lvl_ok = '0;
        run(10);
        check("R6", "short pulse invalid_n", invalid_n, 0);

        phase = "R7"; pump_only = 0; lvl_ok = 2'b10;
        run(2 + INVH);
        check("R4", "invalid_n after rise", invalid_n, 1);
        run(1);
        check("R7", "auto wake pump_en", pump_en, 1);
        run(30);
        check("R3", "auto pump-only cycles", pump_only, WAKE);

        phase = "R5";
        for (int k = 0; k < 3; k++) begin
            lvl_ok = '0; run(INVL - 1); lvl_ok = 2'b01; run(1);
        end
        check("R5", "restarted loss count", invalid_n, 1);
        lvl_ok = '0;
        run(2 + INVL);
        check("R5", "invalid_n after loss", invalid_n, 0);
        run(2);
        check("R8", "powered down after loss", pump_en, 0);

        phase = "R9"; lvl_ok = 2'b01; run(5); lvl_ok = '0;
        run(40);
        check("R9", "grace expired tx_en", tx_en, 0);
        lvl_ok = 2'b01; run(5); lvl_ok = '0; run(14); lvl_ok = 2'b01;
        run(20);
        check("R9", "grace rescued tx_en", tx_en, 1);

        phase = "R1"; force_off_n = 0;
        run(2);
        check("R1", "force off over activity", pump_en, 0);
        run(2);
        finish_up();
    end
endmodule